// File: doc/BRIEF.md
# Channel Activity Power Manager

This block decides, for each of three low-frequency receive channels, whether that channel's pattern correlator should be clocked. It runs from the slow crystal clock of the wakeup receiver. Each channel has an enable input from the configuration registers and an asynchronous signal-detect input from its envelope detector. An enabled channel rests in standby with its correlator clock gated. When activity is seen, it moves to receive and its correlator is clocked. It goes back to standby once the detector has been quiet for a fixed number of clock cycles.

When a channel drops back from receive to standby, a single-cycle correlator reset is produced, so the next wakeup frame is scanned from a clean state. A global correlator-off input masks every clock enable at once. It does not disturb the channel state machines, so releasing it restores the enables at once. When no channel is enabled, a sleep indication is raised. The register file that supplies the enables stays outside this block.

All pins are plain level control and status. There is no data stream and no handshake.

Top module: `chan_power_mgr`

## Requirements
- R1: While reset is held and on the first cycle after it, every channel reports standby, with all correlator clock enables low, all correlator resets low and sleep low.
- R2: A channel whose enable input is low at a rising edge shows the off state after that edge. It stays off, with its clock enable low, for as long as the enable stays low, whatever its signal-detect input does.
- R3: The sleep output is high exactly when all three channels are in the off state. Re-enabling any channel moves that channel to standby on the next edge and lowers sleep.
- R4: A standby channel whose signal-detect input goes high (and stays high across the edges) shows the receive state after the third rising edge: two synchronizer flops, then the state register. It is never seen in receive on the cycle directly after being off. With correlator-off low, its clock enable is high exactly while it is in receive.
- R5: A receive channel stays in receive while its synchronized detect keeps being seen high at least once every 688 cycles. Each cycle with detect high restarts the 688-cycle window. After detect falls, the channel shows standby after rising edge number 690, counted from that fall. It still shows receive after edge 689.
- R6: While correlator-off is high, every clock enable is low and the channel states keep evolving as usual. Dropping correlator-off restores the enables of channels in receive within the same cycle.
- R7: A channel's correlator reset is high for exactly one cycle, the first cycle of standby after a timeout from receive. Leaving receive because the enable was cleared produces no reset pulse.
- R8: Channels are independent: the activity and timeout of one channel leave the state of the others unchanged.
- R9: State encoding on ch_state: channel i occupies bits [2i+1:2i], with 2'b00 off, 2'b01 standby and 2'b10 receive. Clock enable and reset bit i belong to channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_enable | input | 3 | Per-channel enable from configuration |
| corr_off | input | 1 | Global correlator clock kill |
| sig_detect | input | 3 | Per-channel asynchronous activity detect |
| corr_clk_en | output | 3 | Per-channel correlator clock enable |
| corr_rst | output | 3 | Per-channel one-cycle correlator reset |
| ch_state | output | 6 | Packed per-channel state, 2 bits each |
| sleep | output | 1 | All channels off |

## Verification
The bench samples the timeout at both edges of the window: one edge before expiry and at expiry, after a long quiet gap and again after a single-cycle retrigger. An off-by-one counter or a retrigger that fails to reload would leave receive one cycle early or drop out in the middle of a frame. It checks that a disable taken during receive gives no correlator reset, which a design keyed on "left receive" would emit. It also checks that correlator-off masks the enables without freezing the state, which a design that gated the state machine would get wrong on release. Independence is checked by timing out one channel while another sits in receive.

// File: rtl/chpm_pkg.sv
package chpm_pkg;
  typedef enum logic [1:0] {
    CH_OFF  = 2'b00,
    CH_STBY = 2'b01,
    CH_RX   = 2'b10
  } ch_state_e;
endpackage

// File: rtl/chpm_sync.sv
module chpm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/chpm_channel.sv
module chpm_channel
  import chpm_pkg::*;
#(
  parameter int TIMEOUT_CYC = 688
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      det,
  output ch_state_e state,
  output logic      rst_pulse
);
  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_CYC - 1);

  ch_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pls_d, pls_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pls_d = 1'b0;
    unique case (st_q)
      CH_OFF: begin
        if (en) st_d = CH_STBY;
      end
      CH_STBY: begin
        if (!en) begin
          st_d = CH_OFF;
        end else if (det) begin
          st_d  = CH_RX;
          cnt_d = LOAD;
        end
      end
      CH_RX: begin
        if (!en) begin
          st_d = CH_OFF;
        end else if (det) begin
          cnt_d = LOAD;
        end else if (cnt_q == '0) begin
          st_d  = CH_STBY;
          pls_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = CH_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_STBY;
      cnt_q <= '0;
      pls_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign state     = st_q;
  assign rst_pulse = pls_q;
endmodule

// File: rtl/chan_power_mgr.sv
module chan_power_mgr
  import chpm_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int TIMEOUT_CYC = 688,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     ch_enable,
  input  logic                  corr_off,
  input  logic [NUM_CH-1:0]     sig_detect,
  output logic [NUM_CH-1:0]     corr_clk_en,
  output logic [NUM_CH-1:0]     corr_rst,
  output logic [2*NUM_CH-1:0]   ch_state,
  output logic                  sleep
);
  logic [NUM_CH-1:0] det_s;
  logic [NUM_CH-1:0] is_off;

  chpm_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sig_detect),
    .q_sync  (det_s)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ch_state_e st;
    chpm_channel #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ch_enable[i]),
      .det       (det_s[i]),
      .state     (st),
      .rst_pulse (corr_rst[i])
    );
    assign ch_state[2*i +: 2] = st;
    assign corr_clk_en[i]     = (st == CH_RX) & ~corr_off;
    assign is_off[i]          = (st == CH_OFF);
  end

  assign sleep = &is_off;
endmodule

// File: rtl/chpm_checker.sv
module chpm_checker #(
  parameter int NUM_CH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   ch_enable,
  input logic                corr_off,
  input logic [NUM_CH-1:0]   corr_clk_en,
  input logic [NUM_CH-1:0]   corr_rst,
  input logic [2*NUM_CH-1:0] ch_state,
  input logic                sleep
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r2_disabled_goes_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_enable[i] |=> ch_state[2*i +: 2] == 2'b00);
    a_r4_clk_only_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
      corr_clk_en[i] |-> (ch_state[2*i +: 2] == 2'b10) && !corr_off);
    a_r4_no_off_to_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_state[2*i +: 2] == 2'b10) |-> $past(ch_state[2*i +: 2]) != 2'b00);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      corr_rst[i] |=> !corr_rst[i]);
    a_r7_pulse_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      corr_rst[i] |-> (ch_state[2*i +: 2] == 2'b01) && ($past(ch_state[2*i +: 2]) == 2'b10));
  end

  a_r6_global_kill: assert property (@(posedge clk) disable iff (!rst_n)
    corr_off |-> corr_clk_en == '0);
  a_r3_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (corr_clk_en == '0) && (corr_rst == '0));
endmodule

bind chan_power_mgr chpm_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_enable   (ch_enable),
  .corr_off    (corr_off),
  .corr_clk_en (corr_clk_en),
  .corr_rst    (corr_rst),
  .ch_state    (ch_state),
  .sleep       (sleep)
);

// File: tb/sim_chan_power_mgr.sv
module sim_chan_power_mgr;
  localparam int T = 688;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] en = 3'b111;
  logic       coff = 1'b0;
  logic [2:0] sd = 3'b000;
  logic [2:0] clk_en, crst;
  logic [5:0] st;
  logic       slp;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chan_power_mgr u0 (
    .clk(clk), .rst_n(rst_n), .ch_enable(en), .corr_off(coff),
    .sig_detect(sd), .corr_clk_en(clk_en), .corr_rst(crst),
    .ch_state(st), .sleep(slp)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 states", {2'b0, st}, 8'h15);
    chk("R1 clk_en", {5'b0, clk_en}, 8'h0);
    chk("R1 rst", {5'b0, crst}, 8'h0);
    chk("R1 sleep", {7'b0, slp}, 8'h0);
  endtask

  task automatic t_rise();
    sd[0] = 1'b1;
    step(2);
    chk("R4 ch0 still standby after 2 edges", {6'b0, st[1:0]}, 8'h1);
    step(1);
    chk("R4 ch0 receive after 3 edges", {6'b0, st[1:0]}, 8'h2);
    chk("R4 clk_en ch0", {5'b0, clk_en}, 8'h1);
    chk("R9 others standby", {4'b0, st[5:2]}, 8'h5);
  endtask

  task automatic t_timeout();
    step(5);
    sd[0] = 1'b0;
    step(300);
    chk("R5 ch0 held in gap", {6'b0, st[1:0]}, 8'h2);
    sd[0] = 1'b1;
    step(1);
    sd[0] = 1'b0;
    step(T + 1);
    chk("R5 ch0 receive one edge before expiry", {6'b0, st[1:0]}, 8'h2);
    chk("R7 no reset before expiry", {5'b0, crst}, 8'h0);
    step(1);
    chk("R5 ch0 standby at expiry", {6'b0, st[1:0]}, 8'h1);
    chk("R7 reset pulse ch0", {5'b0, crst}, 8'h1);
    chk("R4 clk_en off in standby", {5'b0, clk_en}, 8'h0);
    step(1);
    chk("R7 reset one cycle", {5'b0, crst}, 8'h0);
  endtask

  task automatic t_global_off();
    sd[1] = 1'b1;
    step(3);
    chk("R4 ch1 receive", {6'b0, st[3:2]}, 8'h2);
    coff = 1'b1;
    #1;
    chk("R6 enables masked", {5'b0, clk_en}, 8'h0);
    step(4);
    chk("R6 state kept", {6'b0, st[3:2]}, 8'h2);
    coff = 1'b0;
    #1;
    chk("R6 enables restored", {5'b0, clk_en}, 8'h2);
  endtask

  task automatic t_disable();
    en[1] = 1'b0;
    step(1);
    chk("R2 ch1 off", {6'b0, st[3:2]}, 8'h0);
    chk("R7 no reset on disable", {5'b0, crst}, 8'h0);
    step(5);
    chk("R2 ch1 stays off with detect", {6'b0, st[3:2]}, 8'h0);
    chk("R2 clk_en low", {5'b0, clk_en}, 8'h0);
    sd[1] = 1'b0;
  endtask

  task automatic t_sleep();
    en = 3'b000;
    step(1);
    chk("R3 sleep set", {7'b0, slp}, 8'h1);
    chk("R3 all off", {2'b0, st}, 8'h00);
    en[2] = 1'b1;
    step(1);
    chk("R3 ch2 standby", {2'b0, st}, 8'h10);
    chk("R3 sleep cleared", {7'b0, slp}, 8'h0);
    en = 3'b111;
    step(1);
  endtask

  task automatic t_indep();
    sd[2] = 1'b1;
    sd[0] = 1'b1;
    step(3);
    chk("R8 ch0 and ch2 receive", {2'b0, st}, 8'h26);
    sd[0] = 1'b0;
    step(T + 2);
    chk("R8 ch0 timed out, ch2 kept", {2'b0, st}, 8'h25);
    chk("R8 reset ch0 only", {5'b0, crst}, 8'h1);
    chk("R8 clk_en ch2 only", {5'b0, clk_en}, 8'h4);
    sd[2] = 1'b0;
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_rise();
    t_timeout();
    t_global_off();
    t_disable();
    t_sleep();
    t_indep();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule